// File: doc/BRIEF.md
# Hardware Cursor Window Locator

The locator sits beside a display pipe's raster counter. For every pixel coordinate the pipe hands it, the block decides whether that pixel falls inside a small cursor rectangle. For a covered pixel it returns the byte address of the matching texel in a linear 32-bit ARGB cursor image, along with the pixel's coordinates inside the cursor. Pixel fetch, blending and colour processing happen downstream.

The cursor is set up by a handful of plain configuration pins. A packed position word gives each axis a sign flag and a magnitude, so the cursor can hang off the left or top screen edge. A two-bit size select picks the width. An optional reduced-height field allows a cursor that is shorter than it is wide. A rotation flag makes the address walk backwards from the last texel. Raster coordinates enter on a valid/ready stream and results leave on a valid/ready stream through a single register stage.

Back-pressure rules: `px_ready` is high whenever the output register is empty or is being drained in the same cycle (`rs_ready` high). An input beat is taken on a clock edge where `px_valid` and `px_ready` are both high. While `rs_valid` is high and `rs_ready` is low, every `rs_*` output holds its value.

Top module: `cursor_locator`

## Requirements
- R1: Position word layout. X uses bits [15:0], with the magnitude in [MAG_W-1:0] and the sign in bit 15. Y uses bits [31:16], with the magnitude in [16+MAG_W-1:16] and the sign in bit 31. A set sign makes the coordinate the negative of its magnitude, so a cursor can extend past the left or top edge.
- R2: Size select `cfg_size` picks the width: 1 gives 64, 2 gives 128, 3 gives 256. A value of 0 forces `rs_hit` low whatever the position.
- R3: With `cfg_short_en` low, the height equals the width. A pixel at local row width-1 is covered, and one at local row width is not.
- R4: With `cfg_short_en` high and rotation off, the height is `cfg_rows_m1`+1. A height below 8 or above the width disables the cursor (`rs_hit` low).
- R5: With `cfg_rot180` high, `cfg_short_en` is ignored and the cursor is square.
- R6: Unrotated, a covered pixel's address is `cfg_base` + (local_y*width + local_x)*4, modulo 2^ADDR_W.
- R7: Rotated, a covered pixel's address is `cfg_base` + (height*width - 1)*4 - (local_y*width + local_x)*4. Local (0,0) therefore maps to the last texel.
- R8: A pixel is covered when 0 <= raster_x - X < width and 0 <= raster_y - Y < height. In that case `rs_lx`/`rs_ly` are these differences. Otherwise `rs_hit`, `rs_addr`, `rs_lx` and `rs_ly` are all zero.
- R9: A beat taken at one clock edge appears on the `rs_*` outputs after that same edge. `px_ready` = !rs_valid || rs_ready, and outputs hold while stalled.
- R10: After reset, `rs_valid` is low and `px_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pos | input | 32 | Packed sign-magnitude X/Y position |
| cfg_size | input | 2 | Width select, 0 = off |
| cfg_short_en | input | 1 | Reduced-height enable |
| cfg_rows_m1 | input | 8 | Reduced height minus one |
| cfg_rot180 | input | 1 | 180-degree rotation |
| cfg_base | input | 32 | Byte base address of cursor image |
| px_valid | input | 1 | Raster beat valid |
| px_ready | output | 1 | Raster beat accepted |
| px_x | input | 13 | Raster column |
| px_y | input | 13 | Raster row |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Result consumed |
| rs_hit | output | 1 | Pixel inside cursor |
| rs_addr | output | 32 | Texel byte address |
| rs_lx | output | 8 | Local cursor column |
| rs_ly | output | 8 | Local cursor row |

## Verification
The bench uses the default parameters: 13-bit raster, 12-bit magnitudes, an 8-bit local coordinate (so widths up to 256) and a 32-bit address. With these values every width can be selected. The magnitudes allow positions to push the cursor well past the left and top edges, where local coordinates start above zero. The full 256x256 rotated offset (65535 texels) is also reachable, which exercises the widest offset arithmetic.

// File: rtl/cursor_loc_pkg.sv
package cursor_loc_pkg;
  typedef enum logic [1:0] {
    CSZ_OFF  = 2'd0,
    CSZ_NARR = 2'd1,
    CSZ_MID  = 2'd2,
    CSZ_WIDE = 2'd3
  } csize_e;

  localparam int MIN_ROWS = 8;
endpackage

// File: rtl/cursor_cfg_decode.sv
module cursor_cfg_decode
  import cursor_loc_pkg::*;
#(
  parameter int FLD_W = 16,
  parameter int MAG_W = 12,
  parameter int LOC_W = 8,
  parameter int SW    = 15,
  localparam int W_W  = LOC_W + 1
) (
  input  logic [2*FLD_W-1:0] pos_word,
  input  logic [1:0]         size_sel,
  input  logic               short_en,
  input  logic [LOC_W-1:0]   rows_m1,
  input  logic               rot180,
  output logic               win_en,
  output logic [W_W-1:0]     win_w,
  output logic [W_W-1:0]     win_h,
  output logic signed [SW-1:0] org_x,
  output logic signed [SW-1:0] org_y
);
  logic [MAG_W-1:0] mag_x, mag_y;
  logic             neg_x, neg_y;
  logic [W_W-1:0]   short_h;
  logic             short_on;
  csize_e           sz;

  assign mag_x = pos_word[MAG_W-1:0];
  assign neg_x = pos_word[FLD_W-1];
  assign mag_y = pos_word[FLD_W+MAG_W-1:FLD_W];
  assign neg_y = pos_word[2*FLD_W-1];
  assign sz    = csize_e'(size_sel);

  always_comb begin
    org_x = neg_x ? -$signed(SW'(mag_x)) : $signed(SW'(mag_x));
    org_y = neg_y ? -$signed(SW'(mag_y)) : $signed(SW'(mag_y));
  end

  // width is a power of two: smallest step is 2^(LOC_W-2)
  always_comb begin
    win_w = '0;
    for (int k = 1; k < 4; k++) begin
      if (sz == csize_e'(k)) win_w = W_W'(1) << (LOC_W - 3 + k);
    end
  end

  assign short_on = short_en && !rot180;
  assign short_h  = W_W'(rows_m1) + W_W'(1);

  always_comb begin
    win_h  = short_on ? short_h : win_w;
    win_en = (sz != CSZ_OFF);
    if (short_on && ((short_h < W_W'(MIN_ROWS)) || (short_h > win_w)))
      win_en = 1'b0;
  end
endmodule

// File: rtl/cursor_window_test.sv
module cursor_window_test #(
  parameter int RAST_W = 13,
  parameter int LOC_W  = 8,
  parameter int SW     = 15,
  localparam int W_W   = LOC_W + 1
) (
  input  logic [RAST_W-1:0]    rx,
  input  logic [RAST_W-1:0]    ry,
  input  logic signed [SW-1:0] org_x,
  input  logic signed [SW-1:0] org_y,
  input  logic [W_W-1:0]       win_w,
  input  logic [W_W-1:0]       win_h,
  input  logic                 win_en,
  output logic                 hit,
  output logic [LOC_W-1:0]     lx,
  output logic [LOC_W-1:0]     ly
);
  logic signed [SW-1:0] dx, dy;
  logic                 in_x, in_y;

  assign dx = $signed({{(SW-RAST_W){1'b0}}, rx}) - org_x;
  assign dy = $signed({{(SW-RAST_W){1'b0}}, ry}) - org_y;

  assign in_x = !dx[SW-1] && ($unsigned(dx) < {{(SW-W_W){1'b0}}, win_w});
  assign in_y = !dy[SW-1] && ($unsigned(dy) < {{(SW-W_W){1'b0}}, win_h});

  assign hit = win_en && in_x && in_y;
  assign lx  = hit ? dx[LOC_W-1:0] : '0;
  assign ly  = hit ? dy[LOC_W-1:0] : '0;
endmodule

// File: rtl/cursor_addr_gen.sv
module cursor_addr_gen #(
  parameter int LOC_W  = 8,
  parameter int ADDR_W = 32,
  localparam int W_W   = LOC_W + 1,
  localparam int OFF_W = 2 * LOC_W + 1
) (
  input  logic [LOC_W-1:0]  lx,
  input  logic [LOC_W-1:0]  ly,
  input  logic [W_W-1:0]    win_w,
  input  logic [W_W-1:0]    win_h,
  input  logic              rot180,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr
);
  logic [OFF_W-1:0] lin_off, last_off, walk_off;

  assign lin_off  = OFF_W'(ly) * OFF_W'(win_w) + OFF_W'(lx);
  assign last_off = OFF_W'(win_h) * OFF_W'(win_w) - OFF_W'(1);
  assign walk_off = rot180 ? (last_off - lin_off) : lin_off;
  assign addr     = base + ADDR_W'({walk_off, 2'b00});
endmodule

// File: rtl/cursor_locator.sv
module cursor_locator
  import cursor_loc_pkg::*;
#(
  parameter int RAST_W = 13,
  parameter int MAG_W  = 12,
  parameter int FLD_W  = 16,
  parameter int LOC_W  = 8,
  parameter int ADDR_W = 32,
  localparam int SW    = ((RAST_W > MAG_W) ? RAST_W : MAG_W) + 2,
  localparam int W_W   = LOC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*FLD_W-1:0] cfg_pos,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_short_en,
  input  logic [LOC_W-1:0]  cfg_rows_m1,
  input  logic              cfg_rot180,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              px_valid,
  output logic              px_ready,
  input  logic [RAST_W-1:0] px_x,
  input  logic [RAST_W-1:0] px_y,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic              rs_hit,
  output logic [ADDR_W-1:0] rs_addr,
  output logic [LOC_W-1:0]  rs_lx,
  output logic [LOC_W-1:0]  rs_ly
);
  logic                 dec_en;
  logic [W_W-1:0]       dec_w, dec_h;
  logic signed [SW-1:0] dec_x, dec_y;
  logic                 hit_c;
  logic [LOC_W-1:0]     lx_c, ly_c;
  logic [ADDR_W-1:0]    addr_c;
  logic                 take;

  cursor_cfg_decode #(.FLD_W(FLD_W), .MAG_W(MAG_W), .LOC_W(LOC_W), .SW(SW)) u_dec (
    .pos_word(cfg_pos), .size_sel(cfg_size), .short_en(cfg_short_en),
    .rows_m1(cfg_rows_m1), .rot180(cfg_rot180),
    .win_en(dec_en), .win_w(dec_w), .win_h(dec_h), .org_x(dec_x), .org_y(dec_y)
  );

  cursor_window_test #(.RAST_W(RAST_W), .LOC_W(LOC_W), .SW(SW)) u_win (
    .rx(px_x), .ry(px_y), .org_x(dec_x), .org_y(dec_y),
    .win_w(dec_w), .win_h(dec_h), .win_en(dec_en),
    .hit(hit_c), .lx(lx_c), .ly(ly_c)
  );

  cursor_addr_gen #(.LOC_W(LOC_W), .ADDR_W(ADDR_W)) u_addr (
    .lx(lx_c), .ly(ly_c), .win_w(dec_w), .win_h(dec_h),
    .rot180(cfg_rot180), .base(cfg_base), .addr(addr_c)
  );

  assign px_ready = !rs_valid || rs_ready;
  assign take     = px_valid && px_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_addr  <= '0;
      rs_lx    <= '0;
      rs_ly    <= '0;
    end else if (take) begin
      rs_valid <= 1'b1;
      rs_hit   <= hit_c;
      rs_addr  <= hit_c ? addr_c : '0;
      rs_lx    <= lx_c;
      rs_ly    <= ly_c;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_addr) && $stable(rs_hit)
                              && $stable(rs_lx) && $stable(rs_ly));

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_hit |-> rs_addr == '0 && rs_lx == '0 && rs_ly == '0);

  p_off_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && px_ready && cfg_size == 2'd0 |=> rs_valid && !rs_hit);

  p_rot_square_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en && cfg_rot180 |-> dec_h == dec_w);

  p_rows_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> dec_h >= W_W'(MIN_ROWS) && dec_h <= dec_w);
endmodule

// File: tb/sim_cursor_locator.sv
module sim_cursor_locator;
  localparam int CLK_PER = 10;

  logic        clk = 0, rst_n = 0;
  logic [31:0] cfg_pos = 0;
  logic [1:0]  cfg_size = 0;
  logic        cfg_short_en = 0;
  logic [7:0]  cfg_rows_m1 = 0;
  logic        cfg_rot180 = 0;
  logic [31:0] cfg_base = 0;
  logic        px_valid = 0, px_ready;
  logic [12:0] px_x = 0, px_y = 0;
  logic        rs_valid, rs_ready = 1, rs_hit;
  logic [31:0] rs_addr;
  logic [7:0]  rs_lx, rs_ly;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic        act;
    logic [31:0] addr;
    logic [7:0]  lx, ly;
    string       tag;
  } exp_t;
  exp_t q[$];
  string cur_tag = "";

  always #(CLK_PER/2) clk = ~clk;

  cursor_locator u0 (.*);

  function automatic exp_t model();
    exp_t e;
    int x, y, w, h, dx, dy, lin;
    bit shrt, ok;
    x = cfg_pos[15] ? -int'(cfg_pos[11:0]) : int'(cfg_pos[11:0]);
    y = cfg_pos[31] ? -int'(cfg_pos[27:16]) : int'(cfg_pos[27:16]);
    w = (cfg_size == 0) ? 0 : (32 << cfg_size);
    shrt = cfg_short_en && !cfg_rot180;
    h = shrt ? int'(cfg_rows_m1) + 1 : w;
    ok = (w != 0) && (!shrt || (h >= 8 && h <= w));
    dx = int'(px_x) - x;
    dy = int'(px_y) - y;
    e.act = ok && dx >= 0 && dx < w && dy >= 0 && dy < h;
    e.lx = e.act ? dx[7:0] : 8'd0;
    e.ly = e.act ? dy[7:0] : 8'd0;
    lin = dy * w + dx;
    if (!e.act) e.addr = 0;
    else if (cfg_rot180) e.addr = cfg_base + 32'((h * w - 1) * 4) - 32'(lin * 4);
    else e.addr = cfg_base + 32'(lin * 4);
    if (cur_tag != "") e.tag = cur_tag;
    else e.tag = !e.act ? "R8" : (cfg_rot180 ? "R7" : "R6");
    return e;
  endfunction

  task automatic tick();
    exp_t e;
    #1;
    if (rs_valid && rs_ready) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R9: unexpected output beat act=%0b addr=%h, expected none", rs_hit, rs_addr);
      end else begin
        e = q.pop_front();
        if (rs_hit !== e.act || rs_addr !== e.addr || rs_lx !== e.lx || rs_ly !== e.ly) begin
          fails++;
          $display("FAIL %s: act=%0b addr=%h lx=%0d ly=%0d, expected act=%0b addr=%h lx=%0d ly=%0d",
                   e.tag, rs_hit, rs_addr, rs_lx, rs_ly, e.act, e.addr, e.lx, e.ly);
        end
      end
    end
    if (px_valid && px_ready) q.push_back(model());
    @(negedge clk);
  endtask

  task automatic send(string tag, int rx, int ry);
    cur_tag = tag;
    px_x = 13'(rx); px_y = 13'(ry);
    px_valid = 1;
    rs_ready = 1;
    tick();
    px_valid = 0;
    cur_tag = "";
  endtask

  task automatic setcfg(int sx, int mx, int sy, int my, int size, bit sh, int rm1, bit rot, logic [31:0] base);
    cfg_pos = {1'(sy), 3'b0, 12'(my), 1'(sx), 3'b0, 12'(mx)};
    cfg_size = 2'(size); cfg_short_en = sh; cfg_rows_m1 = 8'(rm1);
    cfg_rot180 = rot; cfg_base = base;
  endtask

  task automatic drain();
    px_valid = 0; rs_ready = 1;
    while (q.size() != 0) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_addr;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    checks++;
    if (rs_valid !== 1'b0 || px_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10: rs_valid=%0b px_ready=%0b, expected 0 1", rs_valid, px_ready);
    end
    rst_n = 1;
    @(negedge clk);

    // R2: size select off blanks, widths at edge
    setcfg(0, 100, 0, 100, 0, 0, 0, 0, 32'h1000);
    send("R2", 110, 110);
    for (int s = 1; s < 4; s++) begin
      setcfg(0, 100, 0, 100, s, 0, 0, 0, 32'h2000);
      send("R2", 100 + (32 << s) - 1, 100);
      send("R2", 100 + (32 << s), 100);
    end
    // R1: negative positions hang off edges
    setcfg(1, 10, 1, 5, 1, 0, 0, 0, 32'h0);
    send("R1", 0, 0);
    send("R1", 53, 58);
    send("R1", 54, 0);
    setcfg(0, 0, 1, 70, 1, 0, 0, 0, 32'h0);
    send("R1", 3, 3);
    // R3: square height edge
    setcfg(0, 20, 0, 30, 1, 0, 15, 0, 32'h400);
    send("R3", 20, 30 + 63);
    send("R3", 20, 30 + 64);
    // R4: reduced height
    setcfg(0, 20, 0, 30, 1, 1, 15, 0, 32'h400);
    send("R4", 21, 30 + 15);
    send("R4", 21, 30 + 16);
    setcfg(0, 20, 0, 30, 1, 1, 6, 0, 32'h400);
    send("R4", 21, 31);
    setcfg(0, 20, 0, 30, 1, 1, 7, 0, 32'h400);
    send("R4", 21, 37);
    setcfg(0, 20, 0, 30, 1, 1, 64, 0, 32'h400);
    send("R4", 21, 31);
    setcfg(0, 20, 0, 30, 2, 1, 127, 0, 32'h400);
    send("R4", 21, 30 + 127);
    // R5: rotation ignores reduced height
    setcfg(0, 20, 0, 30, 1, 1, 15, 1, 32'h800);
    send("R5", 25, 30 + 40);
    // R7: rotated corners, widest
    setcfg(0, 0, 0, 0, 3, 0, 0, 1, 32'h10000);
    send("R7", 0, 0);
    send("R7", 255, 255);
    send("R7", 7, 3);
    // R6: unrotated with address wrap
    setcfg(0, 0, 0, 0, 3, 0, 0, 0, 32'hFFFF_FFF0);
    send("R6", 255, 255);
    send("R8", 256, 0);
    drain();

    // R9: stall keeps outputs steady, input refused
    setcfg(0, 5, 0, 5, 1, 0, 0, 0, 32'h300);
    cur_tag = "R9";
    px_x = 9; px_y = 7; px_valid = 1; rs_ready = 0;
    tick();
    hold_addr = rs_addr;
    px_x = 12;
    for (int i = 0; i < 4; i++) begin
      checks++;
      if (rs_valid !== 1'b1 || px_ready !== 1'b0 || rs_addr !== hold_addr) begin
        fails++;
        $display("FAIL R9: valid=%0b ready=%0b addr=%h, expected 1 0 %h", rs_valid, px_ready, rs_addr, hold_addr);
      end
      tick();
    end
    rs_ready = 1;
    tick();
    px_valid = 0;
    cur_tag = "";
    drain();

    // random traffic with back-pressure
    for (int n = 0; n < 4000; n++) begin
      int mx, my, sz, w, rx, ry;
      mx = $urandom_range(0, 300); my = $urandom_range(0, 300);
      sz = $urandom_range(0, 3);
      setcfg($urandom_range(0, 1), mx, $urandom_range(0, 1), my, sz,
             $urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 1), $urandom());
      w = (sz == 0) ? 64 : (32 << sz);
      rx = (cfg_pos[15] ? -mx : mx) + int'($urandom_range(0, w + 40)) - 20;
      ry = (cfg_pos[31] ? -my : my) + int'($urandom_range(0, w + 40)) - 20;
      px_x = 13'((rx < 0) ? 0 : rx);
      px_y = 13'((ry < 0) ? 0 : ry);
      px_valid = ($urandom_range(0, 3) != 0);
      rs_ready = ($urandom_range(0, 3) != 0);
      tick();
    end
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule